// File: doc/BRIEF.md
# Byte-Stream Instruction Decoder Sequencer

This block sits between an instruction fetch stream and an execution stage of a small 8-bit processor. Bytes arrive one at a time over a valid/ready handshake. The first byte of each instruction is an opcode. The block classifies the opcode and works out whether zero, one or two operand bytes follow. It collects those bytes and then presents one decoded record for one clock cycle.

The record carries the following:
- the instruction class;
- the register fields;
- the ALU function;
- the branch condition;
- any immediate byte;
- a 14-bit control-transfer target;
- an I/O port number;
- a halt flag;
- a "taken" bit for control transfers.

The taken bit comes from the condition field and a flag input. The flag input is sampled when the final byte of the instruction is accepted.

Execution, stack storage and program-counter update belong to the consumer of the record. The record gives the consumer everything it needs to steer them.

Top module: `instr_decoder`

## Requirements
- R1: An opcode with bits 7:6 = 11 (other than 8'hFF) gives class 1 (move) with `rec_dst` = bits 5:3 and `rec_src` = bits 2:0. An opcode with bits 7:6 = 10 gives class 2 (ALU on register) with `rec_alu` = bits 5:3 and `rec_src` = bits 2:0.
- R2: Opcodes 8'h00, 8'h01 and 8'hFF give class 0 (halt) with `rec_halt` = 1. This takes priority over the increment, decrement and move forms. No other class sets `rec_halt`.
- R3: An opcode 00 ddd 000 gives class 5 (increment) and 00 ddd 001 gives class 6 (decrement), with `rec_dst` = ddd. When ddd = 111 the opcode gives class 15 (illegal).
- R4: Opcode 00 fff 100 gives class 3 (ALU with immediate, `rec_alu` = fff). Opcode 00 ddd 110 gives class 4 (load immediate, `rec_dst` = ddd). In both cases the next accepted byte is delivered as `rec_imm`.
- R5: Opcodes 01 ccc 000 and 01 xxx 100 give class 10 (jump). Opcodes 01 ccc 010 and 01 xxx 110 give class 11 (call). Each is followed by a low byte and then a high byte. The target is {high[5:0], low}, and high[7:6] are ignored.
- R6: Opcode 00 ccc 011 (conditional) and opcode 00 xxx 111 (unconditional) give class 8 (return) with no operand bytes.
- R7: Opcode 00 nnn 101 gives class 9 (restart) with target nnn×8 and taken = 1.
- R8: `flags_in` bit 0 is carry, bit 1 is zero, bit 2 is sign and bit 3 is parity (1 = even). For conditional forms, condition bits 1:0 pick the flag. Condition bit 2 = 1 makes taken equal that flag, and bit 2 = 0 makes taken equal its inverse. Unconditional jump, call and return always set taken. Non-control classes clear it.
- R9: An opcode 01 ppp pp1 gives class 12 (input) with port = bits 3:1 when bits 5:4 = 00. Otherwise it gives class 13 (output) with port = bits 5:1.
- R10: `in_ready` is high from the first cycle after reset. `rec_valid` pulses high for exactly the one cycle after the final byte of an instruction is accepted, and stays low after non-final bytes and during input stalls.
- R11: Reset drives `rec_valid` low and discards a partly collected instruction, so the next byte is taken as an opcode.
- R12: Opcode 00 0rr 010 gives class 7 (rotate) with `rec_alu` = 0rr. Opcode 00 1xx 010 gives class 15 (illegal).
- R13: Fields that a class does not use read as zero: dst, src, alu, cond, imm, target and port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| flags_in | input | FLAG_W | Carry, zero, sign, parity flags |
| rec_valid | output | 1 | One-cycle decoded-record strobe |
| rec_class | output | 4 | Instruction class code |
| rec_dst | output | 3 | Destination register field |
| rec_src | output | 3 | Source register field |
| rec_alu | output | 3 | ALU function or rotate kind |
| rec_cond | output | 3 | Condition field of conditional forms |
| rec_imm | output | 8 | Immediate data byte |
| rec_target | output | ADDR_W | Control-transfer target address |
| rec_port | output | 5 | I/O port number |
| rec_halt | output | 1 | Halt instruction |
| rec_taken | output | 1 | Control transfer taken |

## Verification
A sequencer stuck in an operand state is visible at the port on the very next opcode. That opcode is swallowed as an operand, so its record comes out late or with the wrong class. It also pulls a later byte into the wrong field.

A wrong operand count shows at once as a pulse that is early or missing, one cycle after the byte in question. For this reason the bench checks `rec_valid` after every byte, not only after the final one.

A corrupted held opcode or low byte appears in the very next record as a wrong class or a wrong target. Reset in mid-instruction is checked by following it with a one-byte opcode and requiring its record to appear at once.

// File: rtl/dec_pkg.sv
package dec_pkg;

  localparam int OPC_W  = 8;
  localparam int FLD_W  = 3;
  localparam int PORT_W = 5;
  localparam int CLS_W  = 4;

  typedef enum logic [CLS_W-1:0] {
    CL_HALT     = 4'd0,
    CL_MOVE     = 4'd1,
    CL_ALU_REG  = 4'd2,
    CL_ALU_IMM  = 4'd3,
    CL_LOAD_IMM = 4'd4,
    CL_INC      = 4'd5,
    CL_DEC      = 4'd6,
    CL_ROTATE   = 4'd7,
    CL_RETURN   = 4'd8,
    CL_RESTART  = 4'd9,
    CL_JUMP     = 4'd10,
    CL_CALL     = 4'd11,
    CL_INPUT    = 4'd12,
    CL_OUTPUT   = 4'd13,
    CL_ILLEGAL  = 4'd15
  } op_class_e;

  typedef enum logic [1:0] {
    SQ_OPCODE = 2'd0,
    SQ_BYTE2  = 2'd1,
    SQ_BYTE3  = 2'd2
  } seq_state_e;

  typedef struct packed {
    op_class_e  cls;
    logic [1:0] nops;       // operand bytes after the opcode
    logic       cond_form;  // taken depends on flags
    logic       ctrl;       // control transfer
  } op_info_t;

endpackage

// File: rtl/opcode_classifier.sv
module opcode_classifier
  import dec_pkg::*;
(
  input  logic [OPC_W-1:0] op,
  output op_info_t         info
);

  logic [FLD_W-1:0] mid;
  logic             reg_is_acc_or_mem;

  assign mid               = op[5:3];
  assign reg_is_acc_or_mem = (mid == 3'd0) || (mid == 3'd7);

  always_comb begin
    info.cls       = CL_ILLEGAL;
    info.nops      = 2'd0;
    info.cond_form = 1'b0;
    info.ctrl      = 1'b0;
    case (op[7:6])
      2'b11: info.cls = (op == 8'hFF) ? CL_HALT : CL_MOVE;
      2'b10: info.cls = CL_ALU_REG;
      2'b01: begin
        if (op[0]) begin
          info.cls = (op[5:4] == 2'b00) ? CL_INPUT : CL_OUTPUT;
        end else begin
          info.nops      = 2'd2;
          info.ctrl      = 1'b1;
          info.cond_form = ~op[2];
          info.cls       = op[1] ? CL_CALL : CL_JUMP;
        end
      end
      default: begin
        if (op[7:1] == 7'd0) begin
          info.cls = CL_HALT;
        end else begin
          case (op[2:0])
            3'b000: info.cls = reg_is_acc_or_mem ? CL_ILLEGAL : CL_INC;
            3'b001: info.cls = reg_is_acc_or_mem ? CL_ILLEGAL : CL_DEC;
            3'b010: info.cls = op[5] ? CL_ILLEGAL : CL_ROTATE;
            3'b011: begin
              info.cls       = CL_RETURN;
              info.ctrl      = 1'b1;
              info.cond_form = 1'b1;
            end
            3'b100: begin
              info.cls  = CL_ALU_IMM;
              info.nops = 2'd1;
            end
            3'b101: begin
              info.cls  = CL_RESTART;
              info.ctrl = 1'b1;
            end
            3'b110: begin
              info.cls  = CL_LOAD_IMM;
              info.nops = 2'd1;
            end
            default: begin
              info.cls  = CL_RETURN;
              info.ctrl = 1'b1;
            end
          endcase
        end
      end
    endcase
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import dec_pkg::*;
#(
  parameter int FLAG_W = 4
) (
  input  logic [FLD_W-1:0]  cond,
  input  logic [FLAG_W-1:0] flags,
  output logic              hit
);

  localparam int SEL_W = $clog2(FLAG_W);

  logic sel_flag;

  assign sel_flag = flags[cond[SEL_W-1:0]];
  assign hit      = cond[FLD_W-1] ? sel_flag : ~sel_flag;

endmodule

// File: rtl/byte_sequencer.sv
module byte_sequencer
  import dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] nops,
  output seq_state_e state,
  output logic       last
);

  seq_state_e state_d;

  always_comb begin
    state_d = state;
    case (state)
      SQ_OPCODE: state_d = (nops != 2'd0) ? SQ_BYTE2 : SQ_OPCODE;
      SQ_BYTE2:  state_d = (nops == 2'd2) ? SQ_BYTE3 : SQ_OPCODE;
      default:   state_d = SQ_OPCODE;
    endcase
  end

  always_comb begin
    case (state)
      SQ_OPCODE: last = accept && (nops == 2'd0);
      SQ_BYTE2:  last = accept && (nops == 2'd1);
      default:   last = accept;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_OPCODE;
    end else if (accept) begin
      state <= state_d;
    end
  end

endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import dec_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int FLAG_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  input  logic [FLAG_W-1:0]    flags_in,
  output logic                 rec_valid,
  output logic [3:0]           rec_class,
  output logic [2:0]           rec_dst,
  output logic [2:0]           rec_src,
  output logic [2:0]           rec_alu,
  output logic [2:0]           rec_cond,
  output logic [7:0]           rec_imm,
  output logic [ADDR_W-1:0]    rec_target,
  output logic [4:0]           rec_port,
  output logic                 rec_halt,
  output logic                 rec_taken
);

  localparam int HI_W  = ADDR_W - OPC_W;
  localparam int RST_W = FLD_W + 3;

  logic             ready_q;
  logic             accept;
  seq_state_e       state;
  logic             last;
  logic [OPC_W-1:0] op_q;
  logic [OPC_W-1:0] lo_q;
  logic [OPC_W-1:0] cur_op;
  logic [OPC_W-1:0] lo_sel;
  op_info_t         info;
  logic             hit;

  logic [CLS_W-1:0]  cls_d;
  logic [FLD_W-1:0]  dst_d, src_d, alu_d, cond_d;
  logic [OPC_W-1:0]  imm_d;
  logic [ADDR_W-1:0] tgt_d;
  logic [PORT_W-1:0] port_d;
  logic              halt_d, taken_d;

  assign accept = in_valid & ready_q;
  assign cur_op = (state == SQ_OPCODE) ? in_byte : op_q;
  assign lo_sel = (state == SQ_BYTE3) ? lo_q : in_byte;

  opcode_classifier u_cls (
    .op   (cur_op),
    .info (info)
  );

  cond_eval #(.FLAG_W(FLAG_W)) u_cond (
    .cond  (cur_op[5:3]),
    .flags (flags_in),
    .hit   (hit)
  );

  byte_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .nops   (info.nops),
    .state  (state),
    .last   (last)
  );

  // record fields, zero where the class does not use them
  always_comb begin
    cls_d   = info.cls;
    dst_d   = '0;
    src_d   = '0;
    alu_d   = '0;
    cond_d  = info.cond_form ? cur_op[5:3] : '0;
    imm_d   = '0;
    tgt_d   = '0;
    port_d  = '0;
    halt_d  = (info.cls == CL_HALT);
    taken_d = info.cond_form ? hit : info.ctrl;
    case (info.cls)
      CL_MOVE:                  begin dst_d = cur_op[5:3]; src_d = cur_op[2:0]; end
      CL_ALU_REG:               begin alu_d = cur_op[5:3]; src_d = cur_op[2:0]; end
      CL_ALU_IMM:               begin alu_d = cur_op[5:3]; imm_d = in_byte; end
      CL_LOAD_IMM:              begin dst_d = cur_op[5:3]; imm_d = in_byte; end
      CL_INC, CL_DEC:           dst_d = cur_op[5:3];
      CL_ROTATE:                alu_d = cur_op[5:3];
      CL_JUMP, CL_CALL:         tgt_d = {in_byte[HI_W-1:0], lo_sel};
      CL_RESTART:               tgt_d = {{(ADDR_W-RST_W){1'b0}}, cur_op[5:3], 3'b000};
      CL_INPUT:                 port_d = {{(PORT_W-3){1'b0}}, cur_op[3:1]};
      CL_OUTPUT:                port_d = cur_op[5:1];
      default:                  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      rec_valid <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rec_valid <= last;
    end
  end

  always_ff @(posedge clk) begin
    if (accept && (state == SQ_OPCODE)) begin
      op_q <= in_byte;
    end
    if (accept && (state == SQ_BYTE2)) begin
      lo_q <= in_byte;
    end
  end

  always_ff @(posedge clk) begin
    if (last) begin
      rec_class  <= cls_d;
      rec_dst    <= dst_d;
      rec_src    <= src_d;
      rec_alu    <= alu_d;
      rec_cond   <= cond_d;
      rec_imm    <= imm_d;
      rec_target <= tgt_d;
      rec_port   <= port_d;
      rec_halt   <= halt_d;
      rec_taken  <= taken_d;
    end
  end

  assign in_ready = ready_q;

endmodule

// File: rtl/dec_checker.sv
module dec_checker #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rec_valid,
  input logic [3:0]        rec_class,
  input logic [2:0]        rec_dst,
  input logic [ADDR_W-1:0] rec_target,
  input logic [4:0]        rec_port,
  input logic              rec_halt
);

  assert_pulse_follows_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(in_valid && in_ready));

  assert_ready_after_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> in_ready);

  assert_incdec_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && (rec_class == 4'd5 || rec_class == 4'd6)) |-> (rec_dst != 3'd7 && rec_dst != 3'd0));

  assert_restart_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_class == 4'd9) |-> (rec_target[2:0] == 3'd0 && rec_target[ADDR_W-1:6] == '0));

  assert_input_port_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_class == 4'd12) |-> (rec_port < 5'd8));

  assert_output_port_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_class == 4'd13) |-> (rec_port >= 5'd8));

  assert_halt_only_halt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_halt) |-> (rec_class == 4'd0));

endmodule

bind instr_decoder dec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .rec_valid  (rec_valid),
  .rec_class  (rec_class),
  .rec_dst    (rec_dst),
  .rec_target (rec_target),
  .rec_port   (rec_port),
  .rec_halt   (rec_halt)
);

// File: tb/sim_instr_decoder.sv
`timescale 1ns/1ps
module sim_instr_decoder;

  typedef struct packed {
    logic [7:0]  b0, b1, b2;
    logic [1:0]  nops;
    logic [3:0]  fl;
    logic [3:0]  cls;
    logic [2:0]  dst, src, alu, cond;
    logic [7:0]  imm;
    logic [13:0] tgt;
    logic [4:0]  port;
    logic        halt, taken;
  } vec_t;

  localparam int NV = 25;
  // b0 b1 b2 nops flags cls dst src alu cond imm tgt port halt taken
  localparam vec_t VECS [NV] = '{
    '{8'hC8,8'h00,8'h00,2'd0,4'h0,4'd1, 3'd1,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'hAB,8'h00,8'h00,2'd0,4'h0,4'd2, 3'd0,3'd3,3'd5,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h00,8'h00,8'h00,2'd0,4'h0,4'd0, 3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b1,1'b0},
    '{8'h01,8'h00,8'h00,2'd0,4'h0,4'd0, 3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b1,1'b0},
    '{8'hFF,8'h00,8'h00,2'd0,4'h0,4'd0, 3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b1,1'b0},
    '{8'h10,8'h00,8'h00,2'd0,4'h0,4'd5, 3'd2,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h19,8'h00,8'h00,2'd0,4'h0,4'd6, 3'd3,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h38,8'h00,8'h00,2'd0,4'h0,4'd15,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h39,8'h00,8'h00,2'd0,4'h0,4'd15,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h24,8'h5A,8'h00,2'd1,4'h0,4'd3, 3'd0,3'd0,3'd4,3'd0,8'h5A,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h36,8'hC3,8'h00,2'd1,4'h0,4'd4, 3'd6,3'd0,3'd0,3'd0,8'hC3,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h44,8'h34,8'hD2,2'd2,4'h0,4'd10,3'd0,3'd0,3'd0,3'd0,8'h00,14'h1234,5'd0, 1'b0,1'b1},
    '{8'h72,8'hFF,8'hFF,2'd2,4'h4,4'd11,3'd0,3'd0,3'd0,3'd6,8'h00,14'h3FFF,5'd0, 1'b0,1'b1},
    '{8'h48,8'h00,8'h40,2'd2,4'h2,4'd10,3'd0,3'd0,3'd0,3'd1,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h3B,8'h00,8'h00,2'd0,4'h8,4'd8, 3'd0,3'd0,3'd0,3'd7,8'h00,14'h0000,5'd0, 1'b0,1'b1},
    '{8'h1B,8'h00,8'h00,2'd0,4'h8,4'd8, 3'd0,3'd0,3'd0,3'd3,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h2F,8'h00,8'h00,2'd0,4'h0,4'd8, 3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b1},
    '{8'h2D,8'h00,8'h00,2'd0,4'h0,4'd9, 3'd0,3'd0,3'd0,3'd0,8'h00,14'h0028,5'd0, 1'b0,1'b1},
    '{8'h47,8'h00,8'h00,2'd0,4'h0,4'd12,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd3, 1'b0,1'b0},
    '{8'h7F,8'h00,8'h00,2'd0,4'h0,4'd13,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd31,1'b0,1'b0},
    '{8'h51,8'h00,8'h00,2'd0,4'h0,4'd13,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd8, 1'b0,1'b0},
    '{8'h1A,8'h00,8'h00,2'd0,4'h0,4'd7, 3'd0,3'd0,3'd3,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h22,8'h00,8'h00,2'd0,4'h0,4'd15,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0000,5'd0, 1'b0,1'b0},
    '{8'h40,8'h01,8'h00,2'd2,4'h1,4'd10,3'd0,3'd0,3'd0,3'd0,8'h00,14'h0001,5'd0, 1'b0,1'b0},
    '{8'h60,8'h80,8'h3F,2'd2,4'h1,4'd10,3'd0,3'd0,3'd0,3'd4,8'h00,14'h3F80,5'd0, 1'b0,1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  in_byte;
  logic        in_ready;
  logic [3:0]  flags_in;
  logic        rec_valid;
  logic [3:0]  rec_class;
  logic [2:0]  rec_dst, rec_src, rec_alu, rec_cond;
  logic [7:0]  rec_imm;
  logic [13:0] rec_target;
  logic [4:0]  rec_port;
  logic        rec_halt, rec_taken;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  instr_decoder u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .in_ready   (in_ready),
    .flags_in   (flags_in),
    .rec_valid  (rec_valid),
    .rec_class  (rec_class),
    .rec_dst    (rec_dst),
    .rec_src    (rec_src),
    .rec_alu    (rec_alu),
    .rec_cond   (rec_cond),
    .rec_imm    (rec_imm),
    .rec_target (rec_target),
    .rec_port   (rec_port),
    .rec_halt   (rec_halt),
    .rec_taken  (rec_taken)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [63:0] rec_now();
    return {20'd0, rec_class, rec_dst, rec_src, rec_alu, rec_cond,
            rec_imm, rec_target, rec_port, rec_halt};
  endfunction

  function automatic logic [63:0] rec_exp(vec_t v);
    return {20'd0, v.cls, v.dst, v.src, v.alu, v.cond, v.imm, v.tgt, v.port, v.halt};
  endfunction

  function automatic string tag_of(logic [3:0] c);
    case (c)
      4'd0:         return "R2";
      4'd1, 4'd2:   return "R1";
      4'd3, 4'd4:   return "R4";
      4'd5, 4'd6:   return "R3";
      4'd7:         return "R12";
      4'd8:         return "R6";
      4'd9:         return "R7";
      4'd10, 4'd11: return "R5";
      4'd12, 4'd13: return "R9";
      default:      return "R3 R12 R13";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one byte for one cycle, then leave the sampler at the next falling edge
  task automatic put_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n    = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    in_byte  = 8'h00;
    flags_in = 4'h0;
    do_reset();

    // R11 R10: reset state
    check(rec_valid == 1'b0, "R11", "rec_valid after reset", 64'(rec_valid), 64'd0);
    check(in_ready == 1'b1, "R10", "in_ready after reset", 64'(in_ready), 64'd1);

    // vector table walk
    for (int i = 0; i < NV; i++) begin
      flags_in = VECS[i].fl;
      put_byte(VECS[i].b0);
      if (VECS[i].nops != 2'd0) begin
        check(rec_valid == 1'b0, "R10", "no strobe after opcode", 64'(rec_valid), 64'd0);
        put_byte(VECS[i].b1);
      end
      if (VECS[i].nops == 2'd2) begin
        check(rec_valid == 1'b0, "R10", "no strobe after low byte", 64'(rec_valid), 64'd0);
        put_byte(VECS[i].b2);
      end
      check(rec_valid == 1'b1, "R10", "strobe after final byte", 64'(rec_valid), 64'd1);
      check(rec_now() == rec_exp(VECS[i]), tag_of(VECS[i].cls), "record fields R13",
            rec_now(), rec_exp(VECS[i]));
      check(rec_taken == VECS[i].taken, "R8", "taken bit", 64'(rec_taken), 64'(VECS[i].taken));
      @(negedge clk);
      check(rec_valid == 1'b0, "R10", "strobe lasts one cycle", 64'(rec_valid), 64'd0);
    end

    // R10: input stall between opcode and immediate
    put_byte(8'h36);
    repeat (3) begin
      @(negedge clk);
      check(rec_valid == 1'b0, "R10", "no strobe during stall", 64'(rec_valid), 64'd0);
    end
    put_byte(8'h77);
    check(rec_valid == 1'b1 && rec_class == 4'd4 && rec_imm == 8'h77, "R4",
          "load immediate after stall", {55'd0, rec_valid, rec_class, 4'd0}, {55'd1, 4'd4, 4'd0});

    // R10: back-to-back single-byte opcodes
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = 8'h10;
    @(negedge clk);
    in_byte  = 8'h19;
    check(rec_valid == 1'b1 && rec_class == 4'd5 && rec_dst == 3'd2, "R10",
          "first of back-to-back", {56'd0, rec_valid, rec_class, rec_dst}, {56'd0, 1'b1, 4'd5, 3'd2});
    @(negedge clk);
    in_valid = 1'b0;
    check(rec_valid == 1'b1 && rec_class == 4'd6 && rec_dst == 3'd3, "R10",
          "second of back-to-back", {56'd0, rec_valid, rec_class, rec_dst}, {56'd0, 1'b1, 4'd6, 3'd3});

    // R11: reset in the middle of a three-byte jump discards it
    put_byte(8'h44);
    put_byte(8'h12);
    do_reset();
    check(rec_valid == 1'b0, "R11", "strobe low after mid reset", 64'(rec_valid), 64'd0);
    put_byte(8'hC8);
    check(rec_valid == 1'b1 && rec_class == 4'd1 && rec_dst == 3'd1, "R11",
          "opcode decoded after mid reset", {56'd0, rec_valid, rec_class, rec_dst},
          {56'd0, 1'b1, 4'd1, 3'd1});

    // R8: same conditional jump, flag flipped between opcode and final byte
    flags_in = 4'h0;
    put_byte(8'h50);            // 01 010 000: jump if sign false
    put_byte(8'h00);
    flags_in = 4'h4;            // sign set before final byte is accepted
    put_byte(8'h00);
    check(rec_taken == 1'b0, "R8", "flags sampled at final byte", 64'(rec_taken), 64'd0);

    finish_run();
  end

endmodule